// File: doc/BRIEF.md
# Trace Program Correlation Message Generator

This block sits beside a processor's program-trace logic and produces correlation messages for the debug trace stream. Each message marks a point where the trace decoder has to resynchronise. The triggering events are:

- the core entering a low-power state in which it no longer executes instructions;
- program trace being switched off for any reason;
- a change of instruction-encoding mode (into or out of the compressed instruction set) that needs its own message.

Each message carries the running instruction count and the branch history that were gathered up to that point. This lets the decoder interpret the instructions that came before the event.

Events are latched as pending requests. When several events are pending, they are served one at a time in a fixed priority order. Each message goes through a simple field packer. The count and history fields have variable length: each is trimmed to its most significant set bit. The finished message is offered to a downstream message queue with a valid/ready handshake. When the queue accepts a message, the block pulses a clear strobe so that the external count and history accumulators start again from empty.

When trace is disabled after a mode switch that did not raise its own message, the block follows the trace-disable message with a second, mode-switch message. This gives the decoder the new mode context.

Top module: `trace_corr_msg_gen`

## Requirements
- R1: While and immediately after reset, `msg_valid` and `acc_clr` are low.
- R2: A `lp_enter` pulse produces one message whose event code (bits 13:10) is 0010.
- R3: A `trc_off` pulse produces a message whose event code is 0001.
- R4: If a mode switch that raised no message of its own (direct branch with `hist_mode` low) occurred since the last mode-switch message, a `trc_off` pulse produces the 0001 message and then, as the very next message, one with event code 0000. The second message carries the cleared count and history and so has length 16.
- R5: A `mode_sw` pulse with `sw_cause`=0 (page crossing) produces a message with event code 0000, whatever the value of `hist_mode`.
- R6: A `mode_sw` pulse with `sw_cause`=1 (direct branch) produces a 0000 message only when `hist_mode` is high. When `hist_mode` is low, no message appears.
- R7: Message bit 0 is sent first. The layout is: bits 5:0 = 6'b100001, bits 9:6 = `src_id`, bits 13:10 = event code. The count field starts at bit 14 and is as long as the position of the count's highest set bit (minimum 1). The history field follows directly after it and is sized the same way. All higher bits are zero.
- R8: `msg_len` equals 14 plus the two field lengths, so it lies between 16 and 54.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_data` and `msg_len` hold steady. `acc_clr` is high exactly in the cycle where `msg_valid` and `msg_ready` are both high.
- R10: Events that arrive in the same cycle become separate messages in the order trace-disable, then follow-up mode switch, then low-power, then mode switch.
- R11: In the cycle after an accepted message, `msg_valid` is low. The next message therefore captures the count and history after they have been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_enter | input | 1 | Pulse: core enters a non-executing low-power state |
| trc_off | input | 1 | Pulse: program trace disabled |
| mode_sw | input | 1 | Pulse: instruction-encoding mode changed |
| sw_cause | input | 1 | Cause of the mode switch: 0 page crossing, 1 direct branch |
| hist_mode | input | 1 | High when trace runs in branch-history mode |
| src_id | input | 4 | Source process identifier placed in each message |
| insn_cnt | input | CNT_W (8) | Running instruction count |
| br_hist | input | HIST_W (32) | Branch history shift register |
| msg_valid | output | 1 | Message offered to the queue |
| msg_ready | input | 1 | Queue accepts the offered message |
| msg_data | output | 54 | Packed message, LSB sent first |
| msg_len | output | 6 | Number of valid bits in `msg_data` |
| acc_clr | output | 1 | Clear strobe for the count and history accumulators |

## Verification
The bench targets four corner cases:

- **Follow-up after a silent direct-branch switch.** A design that forgets the switch would emit a single message. A design that keeps the stale count would send a follow-up longer than 16 bits.
- **Three events raised in one cycle.** A design that merges them, drops one, or orders them wrongly shows a wrong sequence of event codes.
- **Queue stalled for several cycles.** A design that changes its fields while stalled, or clears the accumulators before the handshake completes, is caught.
- **Field extremes.** Zero count with zero history, and a full count with only the top history bit set, catch off-by-one field lengths and a history field placed at a fixed offset instead of directly after the count.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int HDR_W = 14;
  localparam int SRC_W = 4;
  localparam logic [5:0] CORR_TCODE = 6'b100001;

  typedef enum logic [3:0] {
    EC_MODE_SW = 4'd0,
    EC_TRC_OFF = 4'd1,
    EC_LOW_PWR = 4'd2
  } ecode_e;

  // request slots, lowest index wins
  localparam int SLOT_OFF = 0;
  localparam int SLOT_FOL = 1;
  localparam int SLOT_LP  = 2;
  localparam int SLOT_SW  = 3;
  localparam int NUM_SLOT = 4;

  function automatic ecode_e slot_code(input logic [NUM_SLOT-1:0] g);
    ecode_e c;
    c = EC_MODE_SW;
    if (g[SLOT_OFF]) c = EC_TRC_OFF;
    else if (g[SLOT_LP]) c = EC_LOW_PWR;
    return c;
  endfunction
endpackage

// File: rtl/pcm_event_latch.sv
module pcm_event_latch
  import pcm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp_enter,
  input  logic                trc_off,
  input  logic                mode_sw,
  input  logic                sw_cause,
  input  logic                hist_mode,
  input  logic [NUM_SLOT-1:0] take,
  output logic [NUM_SLOT-1:0] pend
);
  logic sw_seen;
  logic loud_sw;
  logic quiet_sw;
  logic [NUM_SLOT-1:0] raise;

  assign loud_sw  = mode_sw && (!sw_cause || hist_mode);
  assign quiet_sw = mode_sw && sw_cause && !hist_mode;

  always_comb begin
    raise = '0;
    raise[SLOT_OFF] = trc_off;
    raise[SLOT_FOL] = trc_off && (sw_seen || quiet_sw);
    raise[SLOT_LP]  = lp_enter;
    raise[SLOT_SW]  = loud_sw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      sw_seen <= 1'b0;
    end else begin
      pend <= (pend & ~take) | raise;
      if (trc_off)
        sw_seen <= 1'b0;
      else if (quiet_sw)
        sw_seen <= 1'b1;
      else if (take[SLOT_SW])
        sw_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_arbiter.sv
module pcm_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/pcm_packer.sv
module pcm_packer
  import pcm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HIST_W = 32,
  parameter int DATA_W = HDR_W + CNT_W + HIST_W,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [HIST_W-1:0] hist,
  input  logic [SRC_W-1:0]  src,
  input  ecode_e            code,
  output logic [DATA_W-1:0] data,
  output logic [LEN_W-1:0]  len
);
  localparam int MAX_W = (CNT_W > HIST_W) ? CNT_W : HIST_W;

  function automatic logic [LEN_W-1:0] sig_len(input logic [MAX_W-1:0] v);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1);
    for (int i = 0; i < MAX_W; i++)
      if (v[i]) n = LEN_W'(i + 1);
    return n;
  endfunction

  logic [LEN_W-1:0] cnt_len;
  logic [LEN_W-1:0] hist_len;

  assign cnt_len  = sig_len(MAX_W'(cnt));
  assign hist_len = sig_len(MAX_W'(hist));
  assign len      = LEN_W'(HDR_W) + cnt_len + hist_len;

  always_comb begin
    data = '0;
    data[5:0]   = CORR_TCODE;
    data[9:6]   = src;
    data[13:10] = code;
    data = data | (DATA_W'(cnt) << HDR_W)
                | (DATA_W'(hist) << (LEN_W'(HDR_W) + cnt_len));
  end
endmodule

// File: rtl/trace_corr_msg_gen.sv
module trace_corr_msg_gen
  import pcm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HIST_W = 32,
  localparam int DATA_W = HDR_W + CNT_W + HIST_W,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_enter,
  input  logic              trc_off,
  input  logic              mode_sw,
  input  logic              sw_cause,
  input  logic              hist_mode,
  input  logic [SRC_W-1:0]  src_id,
  input  logic [CNT_W-1:0]  insn_cnt,
  input  logic [HIST_W-1:0] br_hist,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DATA_W-1:0] msg_data,
  output logic [LEN_W-1:0]  msg_len,
  output logic              acc_clr
);
  logic [NUM_SLOT-1:0] pend;
  logic [NUM_SLOT-1:0] grant;
  logic [NUM_SLOT-1:0] take;
  logic                any_pend;
  logic                load;
  logic                accept;
  ecode_e              cur_code;
  logic [DATA_W-1:0]   pk_data;
  logic [LEN_W-1:0]    pk_len;

  pcm_event_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_enter  (lp_enter),
    .trc_off   (trc_off),
    .mode_sw   (mode_sw),
    .sw_cause  (sw_cause),
    .hist_mode (hist_mode),
    .take      (take),
    .pend      (pend)
  );

  pcm_arbiter #(.N(NUM_SLOT)) u_arb (
    .req   (pend),
    .grant (grant),
    .any   (any_pend)
  );

  assign load     = any_pend && !msg_valid;
  assign take     = load ? grant : '0;
  assign cur_code = slot_code(grant);
  assign accept   = msg_valid && msg_ready;
  assign acc_clr  = accept;

  pcm_packer #(.CNT_W(CNT_W), .HIST_W(HIST_W)) u_pack (
    .cnt  (insn_cnt),
    .hist (br_hist),
    .src  (src_id),
    .code (cur_code),
    .data (pk_data),
    .len  (pk_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      msg_len   <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_data  <= pk_data;
      msg_len   <= pk_len;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_corr_msg_gen_chk.sv
module trace_corr_msg_gen_chk #(
  parameter int DATA_W = 54,
  parameter int LEN_W  = 6,
  parameter int NSLOT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [DATA_W-1:0] msg_data,
  input logic [LEN_W-1:0]  msg_len,
  input logic              acc_clr,
  input logic [NSLOT-1:0]  grant,
  input logic              load
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !msg_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_len));

  p_clr_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> !msg_valid);

  p_tcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[5:0] == 6'b100001);

  p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_len >= LEN_W'(16)) && (msg_len <= LEN_W'(DATA_W)));

  p_code_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[13:10] <= 4'd2);

  p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_load_offers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> msg_valid);
endmodule

bind trace_corr_msg_gen trace_corr_msg_gen_chk #(
  .DATA_W (DATA_W),
  .LEN_W  (LEN_W),
  .NSLOT  (pcm_pkg::NUM_SLOT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_data  (msg_data),
  .msg_len   (msg_len),
  .acc_clr   (acc_clr),
  .grant     (grant),
  .load      (load)
);

// File: tb/trace_corr_msg_gen_bench.sv
`timescale 1ns/1ps
module trace_corr_msg_gen_bench;
  localparam int CW = 8;
  localparam int HW = 32;
  localparam int DW = 14 + CW + HW;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lp_enter = 1'b0, trc_off = 1'b0, mode_sw = 1'b0;
  logic          sw_cause = 1'b0, hist_mode = 1'b0;
  logic [3:0]    src_id = 4'h0;
  logic [CW-1:0] insn_cnt = '0;
  logic [HW-1:0] br_hist = '0;
  logic          msg_valid, msg_ready = 1'b0, acc_clr;
  logic [DW-1:0] msg_data;
  logic [LW-1:0] msg_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_corr_msg_gen u_trace_corr_msg_gen (
    .clk(clk), .rst_n(rst_n), .lp_enter(lp_enter), .trc_off(trc_off),
    .mode_sw(mode_sw), .sw_cause(sw_cause), .hist_mode(hist_mode),
    .src_id(src_id), .insn_cnt(insn_cnt), .br_hist(br_hist),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .msg_len(msg_len), .acc_clr(acc_clr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--)
      if (v[i]) return i + 1;
    return 1;
  endfunction

  // bench's own message builder: append bits one at a time, first sent first
  function automatic logic [63:0] build(input int code, input logic [63:0] c,
                                        input logic [63:0] h, input logic [3:0] s);
    logic [63:0] m;
    int p;
    m = '0;
    p = 0;
    for (int i = 0; i < 6; i++) begin m[p] = (6'b100001 >> i) & 1'b1; p++; end
    for (int i = 0; i < 4; i++) begin m[p] = s[i]; p++; end
    for (int i = 0; i < 4; i++) begin m[p] = (code >> i) & 1; p++; end
    for (int i = 0; i < width_of(c, CW); i++) begin m[p] = c[i]; p++; end
    for (int i = 0; i < width_of(h, HW); i++) begin m[p] = h[i]; p++; end
    return m;
  endfunction

  task automatic pulse(input bit off, input bit lp, input bit sw, input bit cause);
    @(negedge clk);
    trc_off = off; lp_enter = lp; mode_sw = sw; sw_cause = cause;
    @(negedge clk);
    trc_off = 0; lp_enter = 0; mode_sw = 0; sw_cause = 0;
  endtask

  // wait for a message, check it, accept it, emulate accumulator clear
  task automatic get_msg(input string req, input int code, input int stall);
    logic [63:0] ec, eh, em;
    int n;
    ec = 64'(insn_cnt);
    eh = 64'(br_hist);
    n = 0;
    while (!msg_valid && n < 20) begin @(negedge clk); n++; end
    chk(msg_valid == 1'b1, req, "message offered", 64'(msg_valid), 1);
    em = build(code, ec, eh, src_id);
    chk(64'(msg_data) == em, req, "message bits", 64'(msg_data), em);
    chk(int'(msg_len) == 14 + width_of(ec, CW) + width_of(eh, HW), "R8", "length",
        64'(msg_len), 64'(14 + width_of(ec, CW) + width_of(eh, HW)));
    chk(acc_clr == 1'b0, "R9", "no clear before ready", 64'(acc_clr), 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(msg_valid && 64'(msg_data) == em, "R9", "held while stalled", 64'(msg_data), em);
    end
    msg_ready = 1'b1;
    #0.5;
    chk(acc_clr == 1'b1, "R9", "clear on accept", 64'(acc_clr), 1);
    @(negedge clk);
    msg_ready = 1'b0;
    insn_cnt = '0;
    br_hist = '0;
    chk(msg_valid == 1'b0, "R11", "gap after accept", 64'(msg_valid), 0);
  endtask

  task automatic expect_quiet(input string req, input int cyc);
    bit seen;
    seen = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (msg_valid) seen = 1; end
    chk(!seen, req, "no message expected", 64'(seen), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!msg_valid && !acc_clr, "R1", "idle in reset", 64'({msg_valid, acc_clr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msg_valid && !acc_clr, "R1", "idle after reset", 64'({msg_valid, acc_clr}), 0);
  endtask

  task automatic t_low_power;
    src_id = 4'hA; insn_cnt = 8'h05; br_hist = 32'h0000_000B;
    pulse(0, 1, 0, 0);
    get_msg("R2", 2, 0);
    expect_quiet("R2", 6);
  endtask

  task automatic t_trace_off;
    src_id = 4'h3; insn_cnt = 8'h41; br_hist = 32'h0001_2345;
    pulse(1, 0, 0, 0);
    get_msg("R3", 1, 0);
    expect_quiet("R3", 6);
  endtask

  task automatic t_page_switch;
    hist_mode = 0; src_id = 4'h5; insn_cnt = 8'h10; br_hist = 32'h0000_0003;
    pulse(0, 0, 1, 0);
    get_msg("R5", 0, 0);
    hist_mode = 1; insn_cnt = 8'h02; br_hist = 32'h0000_00F0;
    pulse(0, 0, 1, 0);
    get_msg("R5", 0, 0);
    hist_mode = 0;
  endtask

  task automatic t_branch_switch;
    hist_mode = 1; src_id = 4'h6; insn_cnt = 8'h07; br_hist = 32'h0000_0055;
    pulse(0, 0, 1, 1);
    get_msg("R6", 0, 0);
    hist_mode = 0; insn_cnt = 8'h09;
    pulse(0, 0, 1, 1);
    expect_quiet("R6", 10);
  endtask

  task automatic t_follow_up;
    // a silent direct-branch switch is pending from t_branch_switch
    src_id = 4'hC; insn_cnt = 8'h03; br_hist = 32'h0000_0005;
    pulse(1, 0, 0, 0);
    get_msg("R4", 1, 0);
    get_msg("R4", 0, 0);
    chk(1'b1, "R4", "follow-up was length 16", 0, 0);
    expect_quiet("R4", 6);
    insn_cnt = 8'h01;
    pulse(1, 0, 0, 0);
    get_msg("R4", 1, 0);
    expect_quiet("R4", 6);
  endtask

  task automatic t_same_cycle;
    hist_mode = 0; src_id = 4'h9; insn_cnt = 8'h22; br_hist = 32'h0000_0101;
    pulse(1, 1, 1, 0);
    get_msg("R10", 1, 0);
    get_msg("R10", 2, 0);
    get_msg("R10", 0, 0);
    expect_quiet("R10", 6);
  endtask

  task automatic t_stall;
    src_id = 4'h1; insn_cnt = 8'h33; br_hist = 32'h0000_7777;
    pulse(0, 1, 0, 0);
    get_msg("R9", 2, 5);
  endtask

  task automatic t_extremes;
    src_id = 4'hF; insn_cnt = 8'hFF; br_hist = 32'h8000_0000;
    pulse(0, 1, 0, 0);
    get_msg("R7", 2, 0);
    chk(1'b1, "R8", "max length case done", 0, 0);
    src_id = 4'h0; insn_cnt = 8'h00; br_hist = 32'h0;
    pulse(0, 1, 0, 0);
    get_msg("R7", 2, 0);
    insn_cnt = 8'h01; br_hist = 32'h0000_0200;
    pulse(0, 1, 0, 0);
    get_msg("R7", 2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_low_power();
    t_trace_off();
    t_page_switch();
    t_branch_switch();
    t_follow_up();
    t_same_cycle();
    t_stall();
    t_extremes();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule